// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Controller

This block produces the single status output that a flash memory controller presents to the system. By default the output is a level indication of the internal write engine: low while the engine is busy and high once it is ready. A memory controller can use this level to hold off accesses to the flash subsystem.

Software can instead switch the pin into a pulse mode. It does this with a two-byte configuration command on the command bus: the opcode byte B8h, then a data byte in the very next cycle. Only bits 1:0 of the data byte are kept. In pulse mode the pin idles high. It emits a fixed-width low pulse when a selected completion event arrives: erase done (which also covers the end of a queued erase sequence), program done, or either of the two. This gives the system an interrupt edge each time an operation finishes. The pulse width is a parameter in clock cycles. It is derived from the clock period so that the low time is about 250 ns.

Top module: `rdy_sig_ctrl`

## Requirements
- R1: After reset the stored mode is 00 (level mode), and completion events produce no pulse.
- R2: A write of B8h followed, in the directly next cycle, by a second write loads bits 1:0 of that second byte as the mode. Bits 7:2 of that byte are ignored.
- R3: If the cycle after the B8h write carries no write, the sequence is abandoned. A later write does not change the mode.
- R4: In mode 00 the output equals the inverse of the busy input in the same cycle: low while busy, high while ready.
- R5: In mode 01, erase completion drives the output low for PULSE_CYC cycles, starting at the clock edge that samples the event. Program completion is ignored.
- R6: In mode 10, program completion produces the pulse and erase completion is ignored.
- R7: In mode 11, either erase completion or program completion produces the pulse.
- R8: In any pulse mode the output is high whenever no pulse is running, whatever the busy input.
- R9: A selected event that arrives during a pulse reloads the timer, so the output stays low for PULSE_CYC cycles after the latest event.
- R10: A mode load cancels any pulse in progress. The output is high after that edge, unless the new mode is 00 and the engine is busy.
- R11: PULSE_CYC is PULSE_NS divided by CLK_PERIOD_NS, rounded up, which is 13 at the defaults (250 ns, 20 ns).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command bus write strobe |
| cmd_data | input | CMD_W | Command or data byte |
| wsm_busy | input | 1 | Write engine busy |
| erase_done | input | 1 | One-cycle erase (or queued erase sequence) completion |
| prog_done | input | 1 | One-cycle program completion |
| sts_o | output | 1 | Ready/busy status pin, active low |

## Verification
The mode register changes at the clock edge that samples the data write, so its effect can be seen directly after that edge. In level mode the output follows the busy input in the same cycle, with no register in the path. A pulse starts at the edge that samples the completion event and ends PULSE_CYC edges later. The bench drives every input 1 ns after a rising edge and reads the output just after each edge. It measures the low time by counting these post-edge samples, so each check falls exactly in the cycle where the result is due.

// File: rtl/rdy_sig_pkg.sv
package rdy_sig_pkg;

   typedef enum logic [1:0] {
      MODE_LEVEL = 2'b00,
      MODE_ERASE = 2'b01,
      MODE_PROG  = 2'b10,
      MODE_BOTH  = 2'b11
   } sts_mode_e;

   // bit index in the mode code that enables each completion source
   localparam int N_EVT     = 2;
   localparam int EVT_ERASE = 0;
   localparam int EVT_PROG  = 1;

endpackage

// File: rtl/rdy_cfg_seq.sv
module rdy_cfg_seq
   import rdy_sig_pkg::*;
#(
   parameter int             CMD_W  = 8,
   parameter logic [CMD_W-1:0] OPCODE = 8'hB8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_data,
   output sts_mode_e        mode_q,
   output logic             load
);

   generate
      if (CMD_W < 2) begin : g_bad_width
         $error("rdy_cfg_seq: CMD_W must hold the two mode bits");
      end
   endgenerate

   logic armed_q;

   // data byte must follow the opcode in the very next cycle
   assign load = armed_q & cmd_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (armed_q) begin
         armed_q <= 1'b0;
      end else begin
         armed_q <= cmd_wr && (cmd_data == OPCODE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_LEVEL;
      end else if (load) begin
         mode_q <= sts_mode_e'(cmd_data[1:0]);
      end
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && cmd_wr) |=> (mode_q == sts_mode_e'($past(cmd_data[1:0]))));

   p_abandon_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !cmd_wr) |=> (!armed_q && $stable(mode_q)));

endmodule

// File: rtl/rdy_evt_sel.sv
module rdy_evt_sel #(
   parameter int N_EVT = 2
) (
   input  logic [N_EVT-1:0] enable,
   input  logic [N_EVT-1:0] done,
   output logic             fire
);

   generate
      if (N_EVT < 1) begin : g_bad_count
         $error("rdy_evt_sel: N_EVT must be at least 1");
      end
   endgenerate

   logic [N_EVT-1:0] hit;

   for (genvar i = 0; i < N_EVT; i++) begin : g_src
      assign hit[i] = enable[i] & done[i];
   end

   assign fire = |hit;

endmodule

// File: rtl/rdy_pulse_tmr.sv
module rdy_pulse_tmr #(
   parameter int CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   output logic low
);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("rdy_pulse_tmr: CYC must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign low = (cnt_q != '0);

   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !clr) |=> (cnt_q == CW'(CYC)));

   p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/rdy_sig_ctrl.sv
module rdy_sig_ctrl
   import rdy_sig_pkg::*;
#(
   parameter int CMD_W         = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int PULSE_NS      = 250,
   parameter int PULSE_CYC     = (PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_data,
   input  logic             wsm_busy,
   input  logic             erase_done,
   input  logic             prog_done,
   output logic             sts_o
);

   generate
      if (CLK_PERIOD_NS < 1 || PULSE_NS < 1) begin : g_bad_time
         $error("rdy_sig_ctrl: timing parameters must be positive");
      end
   endgenerate

   sts_mode_e        mode_q;
   logic             cfg_load;
   logic             evt_fire;
   logic             pulse_low;
   logic [N_EVT-1:0] evt_en;
   logic [N_EVT-1:0] evt_done;

   rdy_cfg_seq #(.CMD_W(CMD_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_data (cmd_data),
      .mode_q   (mode_q),
      .load     (cfg_load)
   );

   assign evt_en             = mode_q;
   assign evt_done[EVT_ERASE] = erase_done;
   assign evt_done[EVT_PROG]  = prog_done;

   rdy_evt_sel #(.N_EVT(N_EVT)) u_sel (
      .enable (evt_en),
      .done   (evt_done),
      .fire   (evt_fire)
   );

   rdy_pulse_tmr #(.CYC(PULSE_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (evt_fire),
      .clr   (cfg_load),
      .low   (pulse_low)
   );

   assign sts_o = (mode_q == MODE_LEVEL) ? ~wsm_busy : ~pulse_low;

   p_load_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && cmd_data[1:0] != 2'b00) |=> sts_o);

   p_prog_ignores_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PROG && erase_done && !prog_done && sts_o && !cmd_wr) |=> sts_o);

   p_erase_ignores_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ERASE && prog_done && !erase_done && sts_o && !cmd_wr) |=> sts_o);

   p_event_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_BOTH && (erase_done || prog_done) && !cmd_wr) |=> !sts_o);

endmodule

// File: tb/rdy_sig_ctrl_tb_top.sv
module rdy_sig_ctrl_tb_top;

   localparam int PW = 13; // R11: ceil(250 / 20)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       wsm_busy = 1'b0;
   logic       erase_done = 1'b0;
   logic       prog_done = 1'b0;
   logic       sts_o;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   rdy_sig_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_data   (cmd_data),
      .wsm_busy   (wsm_busy),
      .erase_done (erase_done),
      .prog_done  (prog_done),
      .sts_o      (sts_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg(input logic [7:0] d);
      cmd_wr = 1'b1; cmd_data = 8'hB8; step();
      cmd_data = d; step();
      cmd_wr = 1'b0; cmd_data = '0; #1;
   endtask

   // drive one completion for one cycle; on return the sampling edge is past
   task automatic fire(input bit ers, input bit prg);
      erase_done = ers; prog_done = prg; step();
      erase_done = 1'b0; prog_done = 1'b0; #1;
   endtask

   task automatic low_len(output int n);
      n = 0;
      while (sts_o == 1'b0 && n < 40) begin
         n++;
         step();
      end
   endtask

   task automatic expect_pulse(input bit ers, input bit prg, input string req);
      int n;
      fire(ers, prg);
      low_len(n);
      chk(n == PW, req, n, PW);
   endtask

   task automatic expect_none(input bit ers, input bit prg, input string req);
      int lows = 0;
      fire(ers, prg);
      for (int i = 0; i < 4; i++) begin
         if (sts_o == 1'b0) lows++;
         step();
      end
      chk(lows == 0, req, lows, 0);
   endtask

   task automatic t_reset();
      wsm_busy = 1'b1; #1;
      chk(sts_o == 1'b0, "R1 level after reset busy", sts_o, 0);
      wsm_busy = 1'b0; #1;
      chk(sts_o == 1'b1, "R1 level after reset ready", sts_o, 1);
      expect_none(1'b1, 1'b1, "R1 no pulse in mode 00");
   endtask

   task automatic t_level();
      step();
      wsm_busy = 1'b1; #1;
      chk(sts_o == 1'b0, "R4 busy low same cycle", sts_o, 0);
      step(); step();
      chk(sts_o == 1'b0, "R4 busy held", sts_o, 0);
      wsm_busy = 1'b0; #1;
      chk(sts_o == 1'b1, "R4 ready high", sts_o, 1);
   endtask

   task automatic t_erase_mode();
      cfg(8'h01);
      wsm_busy = 1'b1; #1;
      chk(sts_o == 1'b1, "R8 idle high while busy", sts_o, 1);
      step();
      chk(sts_o == 1'b1, "R8 idle high next cycle", sts_o, 1);
      expect_pulse(1'b1, 1'b0, "R5 erase pulse width (R11)");
      expect_none(1'b0, 1'b1, "R5 program ignored");
      wsm_busy = 1'b0;
   endtask

   task automatic t_prog_mode();
      cfg(8'h02);
      expect_pulse(1'b0, 1'b1, "R6 program pulse width");
      expect_none(1'b1, 1'b0, "R6 erase ignored");
   endtask

   task automatic t_both();
      cfg(8'h03);
      expect_pulse(1'b1, 1'b0, "R7 erase pulse");
      expect_pulse(1'b0, 1'b1, "R7 program pulse");
   endtask

   task automatic t_reserved();
      cfg(8'hFE); // bits 1:0 = 10
      expect_pulse(1'b0, 1'b1, "R2 reserved bits masked, program pulses");
      expect_none(1'b1, 1'b0, "R2 reserved bits masked, erase ignored");
   endtask

   task automatic t_abandon();
      // mode is 10 here
      cmd_wr = 1'b1; cmd_data = 8'hB8; step();
      cmd_wr = 1'b0; cmd_data = '0; step();
      cmd_wr = 1'b1; cmd_data = 8'h01; step();
      cmd_wr = 1'b0; cmd_data = '0; #1;
      expect_none(1'b1, 1'b0, "R3 abandoned, erase still ignored");
      expect_pulse(1'b0, 1'b1, "R3 abandoned, program still pulses");
   endtask

   task automatic t_restart();
      int lows = 0;
      int n;
      cfg(8'h03);
      fire(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) begin
         if (sts_o == 1'b0) lows++;
         step();
      end
      chk(lows == 5, "R9 low before retrigger", lows, 5);
      fire(1'b0, 1'b1);
      low_len(n);
      chk(n == PW, "R9 full width after retrigger", n, PW);
   endtask

   task automatic t_clear();
      cfg(8'h01);
      fire(1'b1, 1'b0);
      step(); step();
      chk(sts_o == 1'b0, "R10 pulse running", sts_o, 0);
      cfg(8'h03);
      chk(sts_o == 1'b1, "R10 load cancels pulse", sts_o, 1);
      step();
      chk(sts_o == 1'b1, "R10 stays high", sts_o, 1);
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1; #1;
      t_reset();
      t_level();
      t_erase_mode();
      t_prog_mode();
      t_both();
      t_reserved();
      t_abandon();
      t_restart();
      t_clear();
      step();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule